// File: doc/BRIEF.md
# Balanced Binary Reduction Tree

This block folds a vector of N operands into a single scalar using one associative operator, either wrapping addition or signed maximum. The operator is picked at elaboration time and does not change afterwards. A softmax datapath uses two instances: one with the maximum operator finds the largest score, and one with the addition operator sums the exponentials.

The tree is built by recursion. A node covering n operands gives its first operand group to a left subtree and the remaining operands to a right subtree. The left group is the largest power of two that does not exceed n-1. The node then applies the operator with the left result as the first operand. Every level of the tree ends in a register. The shallower subtree is padded with delay registers so that both operands reach a node in the same cycle. A valid bit travels alongside the data, so one new vector can be accepted on every clock.

Operands are packed into one input bus. Element i sits at bits [i*W +: W], and element 0 is the first, or leftmost, operand.

Top module: `reduce_tree`

## Requirements
- R1: After a synchronous reset is released, outValid is low and outData reads zero until the first result arrives.
- R2: A vector sampled with inValid high at a rising edge produces outValid high with its result after the ceil(log2 N)-th rising edge, counting the sampling edge as the first. With the defaults (N=6) this is 3 edges. For N=5 it is 3, and for N=2 it is 1.
- R3: With the addition operator, outData is the sum of all N elements modulo 2^W. There is no widening or saturation, so six elements of 0xFF give 0xFA.
- R4: With the maximum operator, the elements are compared as W-bit two's-complement values and outData is the greatest of them. 0x7F beats 0x80, 0xFD is the result for {-5,-3,-100,-128,-7}, and equal elements give that common value.
- R5: Vectors presented on consecutive cycles each produce exactly one result, one per cycle, in the order they were presented.
- R6: While outValid is low, outData keeps the last result (or zero if there has been none) and does not change.
- R7: For N=1 the block applies no operator and adds no register: outValid follows inValid and outData follows element 0 in the same cycle.
- R8: For N=2 the result is one application of the operator to the two elements, with a latency of one edge.
- R9: inVec contents on cycles where inValid is low are ignored: they produce no result and do not disturb results already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Marks inVec as a vector to reduce this cycle |
| inVec | input | N*W | Packed operands, element i at bits [i*W +: W] |
| outValid | output | 1 | Marks outData as a new result this cycle |
| outData | output | W | Reduced result, held between results |

## Verification
Two things can happen in the same cycle: a new vector enters the first tree level while an older one leaves the final register. A third, earlier vector may still be partway through the tree at that moment. The bench provokes this with back-to-back directed vectors and a long random stream of valid cycles and gaps, during which garbage is driven on the input bus. A scoreboard queue records each expected value along with the cycle it was issued in. Every emerging result is then judged on its value, its order and its exact distance in edges from issue. Any cycle with outValid low is judged on whether the held output stayed unchanged.

// File: rtl/reduce_tree_pkg.sv
package reduce_tree_pkg;

  typedef enum logic {
    RED_ADD = 1'b0,
    RED_MAX = 1'b1
  } redOp_e;

  // Strobes from the valid pipeline to the datapath.
  typedef struct packed {
    logic advance;    // move every internal tree stage one step
    logic finalLoad;  // capture a real result into the output register
  } treeStrobe_t;

  // Size of the left group: largest power of two not above n-1.
  function automatic int leftSpan(input int n);
    int p;
    p = 1;
    while (p * 2 <= n - 1) p = p * 2;
    return p;
  endfunction

endpackage

// File: rtl/reduce_tree_op.sv
module reduce_tree_op
  import reduce_tree_pkg::*;
#(
  parameter int     W  = 8,
  parameter redOp_e OP = RED_ADD
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] res
);

  generate
    if (OP == RED_MAX) begin : g_max
      // Ties keep the left operand.
      assign res = ($signed(lhs) >= $signed(rhs)) ? lhs : rhs;
    end else begin : g_add
      assign res = lhs + rhs;
    end
  endgenerate

endmodule

// File: rtl/reduce_tree_dly.sv
module reduce_tree_dly #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [D+1];

  assign stg[0] = din;

  generate
    for (genvar s = 1; s <= D; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)     stg[s] <= '0;
        else if (en) stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign dout = stg[D];

endmodule

// File: rtl/reduce_tree_node.sv
module reduce_tree_node
  import reduce_tree_pkg::*;
#(
  parameter int     N  = 6,
  parameter int     W  = 8,
  parameter redOp_e OP = RED_ADD
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  logic           finEn,
  input  logic [N*W-1:0] vec,
  output logic [W-1:0]   res
);

  localparam int NL    = leftSpan(N);
  localparam int NR    = N - NL;
  localparam int DL    = $clog2(NL);
  localparam int DR    = $clog2(NR);
  localparam int SLACK = DL - DR;

  logic [W-1:0] leftRes;
  logic [W-1:0] rightRes;
  logic [W-1:0] rightAligned;
  logic [W-1:0] combo;

  generate
    if (NL == 1) begin : g_lleaf
      assign leftRes = vec[W-1:0];
    end else begin : g_lsub
      reduce_tree_node #(.N(NL), .W(W), .OP(OP)) u_left (
        .clk(clk), .rst(rst), .adv(adv), .finEn(adv),
        .vec(vec[NL*W-1:0]), .res(leftRes)
      );
    end

    if (NR == 1) begin : g_rleaf
      assign rightRes = vec[N*W-1:NL*W];
    end else begin : g_rsub
      reduce_tree_node #(.N(NR), .W(W), .OP(OP)) u_right (
        .clk(clk), .rst(rst), .adv(adv), .finEn(adv),
        .vec(vec[N*W-1:NL*W]), .res(rightRes)
      );
    end

    if (SLACK > 0) begin : g_pad
      reduce_tree_dly #(.W(W), .D(SLACK)) u_pad (
        .clk(clk), .rst(rst), .en(adv), .din(rightRes), .dout(rightAligned)
      );
    end else begin : g_nopad
      assign rightAligned = rightRes;
    end
  endgenerate

  reduce_tree_op #(.W(W), .OP(OP)) u_op (
    .lhs(leftRes), .rhs(rightAligned), .res(combo)
  );

  always_ff @(posedge clk) begin
    if (rst)        res <= '0;
    else if (finEn) res <= combo;
  end

endmodule

// File: rtl/reduce_tree_ctrl.sv
module reduce_tree_ctrl
  import reduce_tree_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output treeStrobe_t strobe,
  output logic        outValid
);

  generate
    if (LAT == 1) begin : g_single
      logic validQ;
      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= inValid;
      end
      assign strobe.advance   = inValid;
      assign strobe.finalLoad = inValid;
      assign outValid         = validQ;
    end else begin : g_multi
      logic [LAT-1:0] validPipe;
      always_ff @(posedge clk) begin
        if (rst) validPipe <= '0;
        else     validPipe <= {validPipe[LAT-2:0], inValid};
      end
      // Inner stages move only while something valid still has to move.
      assign strobe.advance   = inValid | (|validPipe[LAT-2:0]);
      assign strobe.finalLoad = validPipe[LAT-2];
      assign outValid         = validPipe[LAT-1];
    end
  endgenerate

endmodule

// File: rtl/reduce_tree.sv
module reduce_tree
  import reduce_tree_pkg::*;
#(
  parameter int     N  = 6,
  parameter int     W  = 8,
  parameter redOp_e OP = RED_ADD
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [N*W-1:0] inVec,
  output logic           outValid,
  output logic [W-1:0]   outData
);

  localparam int LAT = $clog2(N);

  generate
    if (N == 1) begin : g_pass
      assign outValid = inValid;
      assign outData  = inVec;
    end else begin : g_tree
      treeStrobe_t ctrlStrobe;

      reduce_tree_ctrl #(.LAT(LAT)) u_ctrl (
        .clk(clk), .rst(rst), .inValid(inValid),
        .strobe(ctrlStrobe), .outValid(outValid)
      );

      reduce_tree_node #(.N(N), .W(W), .OP(OP)) u_root (
        .clk(clk), .rst(rst),
        .adv(ctrlStrobe.advance), .finEn(ctrlStrobe.finalLoad),
        .vec(inVec), .res(outData)
      );
    end
  endgenerate

endmodule

// File: rtl/reduce_tree_chk.sv
module reduce_tree_chk #(
  parameter int N = 6,
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic         outValid,
  input logic [W-1:0] outData
);

  localparam int LAT = $clog2(N);
  localparam int CW  = $clog2(LAT + 2) + 1;

  generate
    if (LAT > 0) begin : g_seq
      logic [CW-1:0] inFlight;

      always_ff @(posedge clk) begin
        if (rst) inFlight <= '0;
        else     inFlight <= inFlight + CW'(inValid) - CW'(outValid);
      end

      // R1: idle right after reset release
      a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !outValid);

      // R5: never more vectors inside than pipeline stages
      a_r5_inflight_bound: assert property (@(posedge clk) disable iff (rst)
        inFlight <= CW'(LAT));

      // R9: no result without an accepted vector
      a_r9_no_orphan: assert property (@(posedge clk) disable iff (rst)
        outValid |-> (inFlight != '0));

      // R9: empty pipe and no input means no result next cycle
      a_r9_drained_quiet: assert property (@(posedge clk) disable iff (rst)
        (inFlight == '0 && !inValid) |=> !outValid);

      // R6: output held between results
      a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !outValid |-> $stable(outData));
    end else begin : g_comb
      // R7: pass-through valid
      always_comb begin
        a_r7_pass_valid: assert (rst || (outValid == inValid));
      end
    end
  endgenerate

endmodule

bind reduce_tree reduce_tree_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid), .outData(outData)
);

// File: tb/reduce_tree_tb_top.sv
module reduce_tree_tb_top;
  import reduce_tree_pkg::*;

  typedef struct {
    logic [7:0] val;
    int         cyc;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic        inValid = 1'b0;
  logic [47:0] sumVec  = '0;
  logic [39:0] maxVec  = '0;
  logic [15:0] pairVec = '0;
  logic [7:0]  oneVec  = '0;

  logic       mV [3];
  logic [7:0] mD [3];
  logic       oneV;
  logic [7:0] oneD;

  reduce_tree #(.N(6), .W(8), .OP(RED_ADD)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inVec(sumVec),
    .outValid(mV[0]), .outData(mD[0])
  );
  reduce_tree #(.N(5), .W(8), .OP(RED_MAX)) dutMax (
    .clk(clk), .rst(rst), .inValid(inValid), .inVec(maxVec),
    .outValid(mV[1]), .outData(mD[1])
  );
  reduce_tree #(.N(2), .W(8), .OP(RED_MAX)) dutPair (
    .clk(clk), .rst(rst), .inValid(inValid), .inVec(pairVec),
    .outValid(mV[2]), .outData(mD[2])
  );
  reduce_tree #(.N(1), .W(8), .OP(RED_ADD)) dutOne (
    .clk(clk), .rst(rst), .inValid(inValid), .inVec(oneVec),
    .outValid(oneV), .outData(oneD)
  );

  exp_t       sb [3][$];
  logic [7:0] lastOut [3] = '{8'h00, 8'h00, 8'h00};
  int         latExp  [3] = '{3, 3, 1};   // R2 / R8: ceil(log2 N)
  string      tagRes  [3] = '{"R3", "R4", "R8"};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] sumOf(input logic [47:0] v);
    logic [7:0] s = 8'h00;
    for (int i = 0; i < 6; i++) s = s + v[i*8 +: 8];
    return s;
  endfunction

  function automatic logic [7:0] maxOf(input logic [47:0] v, input int n);
    logic [7:0] m = v[7:0];
    for (int i = 1; i < n; i++)
      if ($signed(v[i*8 +: 8]) > $signed(m)) m = v[i*8 +: 8];
    return m;
  endfunction

  // Driver: applies one cycle of stimulus and records expectations.
  task automatic drive(input logic v, input logic [47:0] a,
                       input logic [39:0] m, input logic [15:0] p);
    exp_t e;
    @(negedge clk);
    inValid = v;
    sumVec  = a;
    maxVec  = m;
    pairVec = p;
    oneVec  = a[7:0];
    if (v) begin
      e.cyc = cyc;
      e.val = sumOf(a);               sb[0].push_back(e);
      e.val = maxOf({8'h00, m}, 5);   sb[1].push_back(e);
      e.val = maxOf({32'h0, p}, 2);   sb[2].push_back(e);
    end
    #1;
    check(oneV == v,       "R7", "single-element valid", oneV, v);
    check(oneD == a[7:0],  "R7", "single-element data",  oneD, a[7:0]);
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int k = 0; k < 3; k++) begin
        exp_t e;
        if (mV[k]) begin
          if (sb[k].size() == 0) begin
            check(1'b0, "R9", "result with nothing pending", mD[k], -1);
          end else begin
            e = sb[k].pop_front();
            check(mD[k] == e.val, tagRes[k], "result value", mD[k], e.val);
            check(cyc - e.cyc == latExp[k], "R2", "latency in edges",
                  cyc - e.cyc, latExp[k]);
          end
          lastOut[k] = mD[k];
        end else begin
          check(mD[k] == lastOut[k], "R6", "held output", mD[k], lastOut[k]);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "R5", "watchdog expired", 0, 1);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1: reset state on the tree instances
    for (int k = 0; k < 3; k++) begin
      check(mV[k] == 1'b0, "R1", "outValid after reset", mV[k], 0);
      check(mD[k] == 8'h00, "R1", "outData after reset", mD[k], 0);
    end

    // Directed vectors, back to back (R5).
    drive(1'b1, 48'h0, 40'h0, 16'h0);                                  // zeros
    drive(1'b1, {6{8'hFF}}, {5{8'hFF}}, 16'hFFFF);                     // R3 wrap to 0xFA
    drive(1'b1, 48'h06_05_04_03_02_01, {8'hF9, 8'h80, 8'h9C, 8'hFD, 8'hFB},
          {8'h01, 8'h80});                                             // R4 negatives -> 0xFD; pair -> 0x01
    drive(1'b1, 48'h10_20_30_40_50_60, {8'd100, 8'd4, 8'd3, 8'd2, 8'd1},
          {8'h05, 8'h05});                                             // R4 max last; R8 tie
    drive(1'b1, 48'h80_80_01_01_7F_7F, {8'h80, 8'h80, 8'h80, 8'h80, 8'h7F},
          {8'hFE, 8'hFF});                                             // R4 0x7F beats 0x80; pair -> 0xFF
    drive(1'b1, 48'h11_22_33_44_55_66, {5{8'h09}}, {8'h7F, 8'h80});    // R4 ties
    drive(1'b0, 48'hDEAD_BEEF_CAFE, 40'hAA_BB_CC_DD_EE, 16'h7F7F);     // R9 garbage
    drive(1'b0, 48'h1234_5678_9ABC, 40'h7F_7F_7F_7F_7F, 16'h1234);     // R9 garbage
    drive(1'b1, 48'h01_01_01_01_01_FF, {8'h00, 8'h00, 8'h00, 8'h00, 8'h7F},
          {8'h00, 8'h80});                                             // R4 max first

    // Random stream with gaps (R5, R9).
    for (int n = 0; n < 400; n++) begin
      drive(($urandom % 3) != 0,
            {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF,
            {$urandom, $urandom} & 40'hFF_FFFF_FFFF,
            $urandom & 16'hFFFF);
    end

    // Drain, then nothing may be left or extra (R5).
    for (int n = 0; n < 8; n++) drive(1'b0, 48'hA5A5_A5A5_A5A5, 40'h5A5A_5A5A_5A, 16'hC3C3);
    for (int k = 0; k < 3; k++)
      check(sb[k].size() == 0, "R5", "pending results after drain", sb[k].size(), 0);

    done = 1'b1;
    finishRun();
  end

endmodule